// File: doc/BRIEF.md
# Synchronous SRAM power-down sequencer

This block fronts a small single-port synchronous memory array and puts it into a low-power sleep state when asked, then brings it back. The sleep request is an active-high input with no timing relation to the clock. A two-flop synchronizer brings it into the clock domain. A phase machine then counts a fixed entry window before declaring the array asleep and a fixed recovery window before normal service resumes. While asleep, every command and data input is ignored, the read-data drive enable is withdrawn, and the stored words are kept.

During recovery, reads and idle cycles are served normally. A write in that window is dropped and reported on a one-cycle error pulse. A second error pulse reports a sleep request that was captured while an access was still in flight. That access is still allowed to finish inside the entry window.

A mode input picks the read timing. Held high, which is the level to tie when it is left unused, it gives registered read data two cycles after the command. Held low, it gives data one cycle after the command. The read data bus reads zero whenever no valid read word is presented.

Top module: `sleep_sram_ctrl`

## Requirements
- R1: While reset is asserted and just after it, asleep, recovering, rd_valid and both error pulses are 0, rd_oe is 1 and rd_data is 0.
- R2: With pipe_sel=1, a read accepted on clock edge e presents rd_valid=1 and the word last written to that address during the cycle after edge e+1, for exactly one cycle.
- R3: With pipe_sel=0, a read accepted on edge e presents rd_valid=1 and the stored word during the cycle after edge e, for exactly one cycle.
- R4: If sleep_req rises between two edges and stays high, asleep becomes 1 after the 5th following edge (two synchronizer edges, one decision edge, two entry cycles). While asleep, rd_oe is 0, rd_valid is 0 and rd_data is 0.
- R5: Commands issued while the block is entering sleep or asleep are ignored. No read produces rd_valid and no write changes the array.
- R6: If sleep_req falls between two edges, asleep drops after the 3rd following edge and recovering is 1 for exactly the next two cycles. Service is fully normal after the 5th edge.
- R7: A read accepted during recovery returns the stored word with normal latency.
- R8: A write (cmd_en=1, cmd_we=1) presented on an edge during recovery leaves the array unchanged and raises err_wr_blocked for the one cycle after that edge.
- R9: Array contents are unchanged across a complete sleep and wake sequence.
- R10: The sleep request is acted on at an edge where the block is awake and the synchronized request is high. If on that edge a command is also accepted, or a pipelined read has not yet presented its data, err_sleep_pending is 1 for the following cycle. The outstanding read still presents its data before asleep rises.
- R11: Reset returns the sequencer to the awake state but does not clear the array.
- R12: pipe_sel=1 selects pipelined timing and pipe_sel=0 selects flow-through timing, and both can be used in one run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sleep_req | input | 1 | Asynchronous active-high sleep request |
| pipe_sel | input | 1 | 1 = pipelined reads (tie-high default), 0 = flow-through |
| cmd_en | input | 1 | Command select; 0 is deselect |
| cmd_we | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | ADDR_W | Word address |
| cmd_wdata | input | DATA_W | Write data |
| rd_data | output | DATA_W | Read data, zero when not valid |
| rd_valid | output | 1 | Read word presented this cycle |
| rd_oe | output | 1 | Read data drive enable, low while asleep |
| asleep | output | 1 | Sleep phase |
| recovering | output | 1 | Recovery window |
| err_wr_blocked | output | 1 | Pulse: write dropped in recovery |
| err_sleep_pending | output | 1 | Pulse: sleep requested with an access in flight |

## Verification
The hardest case to reach is the edge where the synchronized request is first acted on while an access is in flight. Its timing depends on the two synchronizer flops, so the stimulus raises the request and holds a read command across three edges, which guarantees a read is accepted on exactly the decision edge. The bench then checks both the pending-error pulse and the late read word before sleep. The recovery window is only two cycles wide, so the bench times a write into one of its edges and a read into the other, then reads the same address again to prove the write had no effect.

// File: rtl/sleep_ctrl_pkg.sv
package sleep_ctrl_pkg;

  typedef enum logic [1:0] {
    PH_AWAKE = 2'd0,
    PH_ENTER = 2'd1,
    PH_SLEEP = 2'd2,
    PH_WAKE  = 2'd3
  } phase_e;

endpackage

// File: rtl/sleep_sync.sv
module sleep_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);

  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] chain_q;

  genvar gi;
  for (gi = 0; gi < STAGES; gi++) begin : g_stage
    if (gi == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[gi] <= 1'b0;
        else        chain_q[gi] <= async_in;
      end
    end else begin : g_rest
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[gi] <= 1'b0;
        else        chain_q[gi] <= chain_q[gi-1];
      end
    end
  end

  assign sync_out = chain_q[LAST];

endmodule

// File: rtl/sleep_fsm.sv
module sleep_fsm
  import sleep_ctrl_pkg::*;
#(
  parameter int ENTRY_CYC = 2,
  parameter int WAKE_CYC  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_s,
  input  logic cmd_en,
  input  logic cmd_we,
  input  logic pipe_sel,
  input  logic rd_pending,
  output logic acc_rd,
  output logic acc_wr,
  output logic asleep,
  output logic recovering,
  output logic err_wr,
  output logic err_pend
);

  localparam int MAX_CYC = (ENTRY_CYC > WAKE_CYC) ? ENTRY_CYC : WAKE_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC) + 1;
  localparam logic [CNT_W-1:0] ENTRY_LOAD = CNT_W'(ENTRY_CYC - 1);
  localparam logic [CNT_W-1:0] WAKE_LOAD  = CNT_W'(WAKE_CYC - 1);

  phase_e           phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             err_wr_q, err_wr_d;
  logic             err_pend_q, err_pend_d;
  logic             gate_open;

  // command gating
  always_comb begin
    gate_open = (phase_q == PH_AWAKE) || (phase_q == PH_WAKE);
    acc_rd    = cmd_en && !cmd_we && gate_open;
    acc_wr    = cmd_en && cmd_we && (phase_q == PH_AWAKE);
  end

  // next state
  always_comb begin
    phase_d    = phase_q;
    cnt_d      = cnt_q;
    err_wr_d   = cmd_en && cmd_we && (phase_q == PH_WAKE);
    err_pend_d = (phase_q == PH_AWAKE) && req_s &&
                 (cmd_en || (pipe_sel && rd_pending));
    unique case (phase_q)
      PH_AWAKE: begin
        if (req_s) begin
          phase_d = PH_ENTER;
          cnt_d   = ENTRY_LOAD;
        end
      end
      PH_ENTER: begin
        if (cnt_q == '0) phase_d = PH_SLEEP;
        else             cnt_d   = cnt_q - 1'b1;
      end
      PH_SLEEP: begin
        if (!req_s) begin
          phase_d = PH_WAKE;
          cnt_d   = WAKE_LOAD;
        end
      end
      PH_WAKE: begin
        if (cnt_q == '0) phase_d = PH_AWAKE;
        else             cnt_d   = cnt_q - 1'b1;
      end
      default: phase_d = PH_AWAKE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q    <= PH_AWAKE;
      cnt_q      <= '0;
      err_wr_q   <= 1'b0;
      err_pend_q <= 1'b0;
    end else begin
      phase_q    <= phase_d;
      cnt_q      <= cnt_d;
      err_wr_q   <= err_wr_d;
      err_pend_q <= err_pend_d;
    end
  end

  assign asleep     = (phase_q == PH_SLEEP);
  assign recovering = (phase_q == PH_WAKE);
  assign err_wr     = err_wr_q;
  assign err_pend   = err_pend_q;

  // R4: sleep is only reached through the entry window
  a_r4_sleep_after_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(asleep) |-> $past(phase_q) == PH_ENTER);

  // R6: recovery always follows a sleep phase
  a_r6_recover_after_sleep: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(recovering) |-> $past(asleep));

  // R10: the pending error only appears as the entry window opens
  a_r10_pend_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
    err_pend |-> (phase_q == PH_ENTER) && ($past(phase_q) == PH_AWAKE));

  // R8: a blocked-write pulse is never raised outside recovery
  a_r8_err_from_recovery: assert property (@(posedge clk) disable iff (!rst_n)
    err_wr |-> $past(recovering));

endmodule

// File: rtl/sleep_array.sv
module sleep_array #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              pipe_sel,
  input  logic              drive_en,
  input  logic              no_write_window,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              s1_valid
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DATA_W-1:0] s1_data_q, s2_data_q;
  logic              s1_v_q, s2_v_q;
  logic [DATA_W-1:0] sel_data;
  logic              sel_v;

  // storage: no reset, contents survive reset and sleep
  always_ff @(posedge clk) begin
    if (wr_en) mem_q[addr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rd_en)  s1_data_q <= mem_q[addr];
    if (s1_v_q) s2_data_q <= s1_data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v_q <= 1'b0;
      s2_v_q <= 1'b0;
    end else begin
      s1_v_q <= rd_en;
      s2_v_q <= s1_v_q;
    end
  end

  always_comb begin
    sel_v    = pipe_sel ? s2_v_q : s1_v_q;
    sel_data = pipe_sel ? s2_data_q : s1_data_q;
    rd_valid = sel_v && drive_en;
    rd_data  = rd_valid ? sel_data : '0;
  end

  assign s1_valid = s1_v_q;

  // R8: the array is never written inside the recovery window
  a_r8_no_write_in_recovery: assert property (@(posedge clk) disable iff (!rst_n)
    no_write_window |-> !wr_en);

  // R5: no access reaches the array while outputs are withdrawn
  a_r5_no_access_asleep: assert property (@(posedge clk) disable iff (!rst_n)
    !drive_en |-> !rd_en && !wr_en);

endmodule

// File: rtl/sleep_sram_ctrl.sv
module sleep_sram_ctrl #(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2,
  parameter int ENTRY_CYC   = 2,
  parameter int WAKE_CYC    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep_req,
  input  logic              pipe_sel,
  input  logic              cmd_en,
  input  logic              cmd_we,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              rd_oe,
  output logic              asleep,
  output logic              recovering,
  output logic              err_wr_blocked,
  output logic              err_sleep_pending
);

  logic req_s;
  logic acc_rd, acc_wr;
  logic asleep_w, recovering_w;
  logic s1_valid;

  sleep_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (sleep_req),
    .sync_out (req_s)
  );

  sleep_fsm #(.ENTRY_CYC(ENTRY_CYC), .WAKE_CYC(WAKE_CYC)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_s      (req_s),
    .cmd_en     (cmd_en),
    .cmd_we     (cmd_we),
    .pipe_sel   (pipe_sel),
    .rd_pending (s1_valid),
    .acc_rd     (acc_rd),
    .acc_wr     (acc_wr),
    .asleep     (asleep_w),
    .recovering (recovering_w),
    .err_wr     (err_wr_blocked),
    .err_pend   (err_sleep_pending)
  );

  sleep_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk             (clk),
    .rst_n           (rst_n),
    .wr_en           (acc_wr),
    .rd_en           (acc_rd),
    .addr            (cmd_addr),
    .wdata           (cmd_wdata),
    .pipe_sel        (pipe_sel),
    .drive_en        (!asleep_w),
    .no_write_window (recovering_w),
    .rd_data         (rd_data),
    .rd_valid        (rd_valid),
    .s1_valid        (s1_valid)
  );

  assign rd_oe      = !asleep_w;
  assign asleep     = asleep_w;
  assign recovering = recovering_w;

endmodule

// File: tb/test_sleep_sram_ctrl.sv
module test_sleep_sram_ctrl;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        sleep_req;
  logic        pipe_sel;
  logic        cmd_en;
  logic        cmd_we;
  logic [5:0]  cmd_addr;
  logic [15:0] cmd_wdata;
  logic [15:0] rd_data;
  logic        rd_valid, rd_oe, asleep, recovering;
  logic        err_wr_blocked, err_sleep_pending;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  sleep_sram_ctrl i_sleep_sram_ctrl (
    .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .pipe_sel(pipe_sel),
    .cmd_en(cmd_en), .cmd_we(cmd_we), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rd_data(rd_data), .rd_valid(rd_valid), .rd_oe(rd_oe), .asleep(asleep),
    .recovering(recovering), .err_wr_blocked(err_wr_blocked),
    .err_sleep_pending(err_sleep_pending)
  );

  typedef struct packed {
    logic        we;
    logic [5:0]  addr;
    logic [15:0] data;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{1'b1, 6'd3,  16'hA5A5},
    '{1'b1, 6'd10, 16'h1234},
    '{1'b0, 6'd3,  16'hA5A5},
    '{1'b1, 6'd3,  16'h0F0F},
    '{1'b0, 6'd3,  16'h0F0F},
    '{1'b0, 6'd10, 16'h1234},
    '{1'b1, 6'd63, 16'hFFFF},
    '{1'b1, 6'd0,  16'hBEEF},
    '{1'b0, 6'd63, 16'hFFFF},
    '{1'b0, 6'd0,  16'hBEEF}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    cmd_en = 1'b0; cmd_we = 1'b0; cmd_addr = '0; cmd_wdata = '0;
  endtask

  task automatic do_write(input logic [5:0] a, input logic [15:0] d);
    cmd_en = 1'b1; cmd_we = 1'b1; cmd_addr = a; cmd_wdata = d;
    @(negedge clk);
    idle();
  endtask

  // read: checks the word at the latency the current mode implies
  task automatic do_read(input logic [5:0] a, input logic [15:0] exp, input string tag);
    cmd_en = 1'b1; cmd_we = 1'b0; cmd_addr = a;
    @(negedge clk);
    idle();
    if (pipe_sel) begin
      check({tag, " early valid"}, {31'd0, rd_valid}, 32'd0);
      @(negedge clk);
    end
    check({tag, " valid"}, {31'd0, rd_valid}, 32'd1);
    check({tag, " data"}, {16'd0, rd_data}, {16'd0, exp});
    @(negedge clk);
    check({tag, " one cycle"}, {31'd0, rd_valid}, 32'd0);
  endtask

  initial begin
    rst_n = 1'b0; sleep_req = 1'b0; pipe_sel = 1'b1; idle();
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 asleep", {31'd0, asleep}, 32'd0);
    check("R1 oe", {31'd0, rd_oe}, 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 flags", {28'd0, recovering, rd_valid, err_wr_blocked, err_sleep_pending}, 32'd0);
    check("R1 data", {16'd0, rd_data}, 32'd0);

    // R2 / R12: vector table in pipelined mode
    foreach (VECS[i]) begin
      if (VECS[i].we) do_write(VECS[i].addr, VECS[i].data);
      else            do_read(VECS[i].addr, VECS[i].data, "R2 pipelined read");
    end

    // R3 / R12: flow-through mode
    pipe_sel = 1'b0;
    @(negedge clk);
    do_read(6'd10, 16'h1234, "R3 flow read");
    do_write(6'd20, 16'h5555);
    do_read(6'd20, 16'h5555, "R3 flow read after write");
    pipe_sel = 1'b1;
    @(negedge clk);

    // R11: reset keeps array contents
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 awake after reset", {31'd0, asleep}, 32'd0);
    do_read(6'd3, 16'h0F0F, "R11 array kept");

    // R4 / R5: sleep entry, commands during entry and sleep
    sleep_req = 1'b1;
    for (int k = 1; k <= 5; k++) begin
      @(negedge clk);
      check("R4 entry timing", {31'd0, asleep}, {31'd0, (k >= 5)});
      check("R10 no pending flag", {31'd0, err_sleep_pending}, 32'd0);
      if (k == 3) begin
        cmd_en = 1'b1; cmd_we = 1'b1; cmd_addr = 6'd3; cmd_wdata = 16'hDEAD;
      end
    end
    check("R4 oe off", {31'd0, rd_oe}, 32'd0);
    cmd_en = 1'b1; cmd_we = 1'b0; cmd_addr = 6'd3;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R5 read ignored asleep", {31'd0, rd_valid}, 32'd0);
      check("R4 data floated", {16'd0, rd_data}, 32'd0);
    end
    idle();

    // R6 / R7 / R8 / R9: exit with write then read in recovery
    sleep_req = 1'b0;
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      if (k <= 5) begin
        check("R6 asleep timing", {31'd0, asleep}, {31'd0, (k < 3)});
        check("R6 recovering timing", {31'd0, recovering}, {31'd0, (k == 3 || k == 4)});
      end
      if (k == 4) check("R8 blocked write flagged", {31'd0, err_wr_blocked}, 32'd1);
      if (k == 5) check("R8 flag is a pulse", {31'd0, err_wr_blocked}, 32'd0);
      if (k == 6) begin
        check("R7 read in recovery valid", {31'd0, rd_valid}, 32'd1);
        check("R8 R9 R5 array unchanged", {16'd0, rd_data}, 32'h0F0F);
      end
      if (k == 3) begin
        cmd_en = 1'b1; cmd_we = 1'b1; cmd_addr = 6'd3; cmd_wdata = 16'h7777;
      end else if (k == 4) begin
        cmd_en = 1'b1; cmd_we = 1'b0; cmd_addr = 6'd3;
      end else begin
        idle();
      end
    end
    do_read(6'd63, 16'hFFFF, "R9 preserved");

    // R10: sleep requested while reads are in flight
    sleep_req = 1'b1;
    cmd_en = 1'b1; cmd_we = 1'b0; cmd_addr = 6'd10;
    for (int k = 1; k <= 5; k++) begin
      @(negedge clk);
      if (k == 3) begin
        check("R10 pending flagged", {31'd0, err_sleep_pending}, 32'd1);
        idle();
      end
      if (k == 4) begin
        check("R10 in-flight read done", {31'd0, rd_valid}, 32'd1);
        check("R10 in-flight data", {16'd0, rd_data}, 32'h1234);
        check("R10 flag pulse", {31'd0, err_sleep_pending}, 32'd0);
      end
      if (k == 5) check("R10 asleep after drain", {31'd0, asleep}, 32'd1);
    end
    sleep_req = 1'b0;
    repeat (5) @(negedge clk);
    check("R6 awake again", {30'd0, asleep, recovering}, 32'd0);
    pipe_sel = 1'b0;
    @(negedge clk);
    do_read(6'd0, 16'hBEEF, "R12 R9 flow after wake");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule